// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block owns the two threshold registers of a synchronous FIFO: the empty offset, which the almost-empty comparator uses, and the full offset, which the almost-full comparator uses. While master reset is held, it samples three strap inputs. One strap picks the load mode, serial or parallel. The three straps together pick one of eight default values, and both offsets take that value. The FIFO storage and the flag comparators sit outside the block. They take the two offsets from its outputs.

Once reset is released, software can rewrite the offsets through the path the mode strap picked. In parallel mode, words come from the FIFO write data bus while the program strobe is high, going first to the empty offset and then to the full offset. In serial mode, bits come in one per cycle through a single-bit input. Whatever the mode, the offsets can be read back on the parallel read data bus, alternating between them in the same order. There is no serial readback path. One clock drives all of this, because the FIFO's write and read sides share a clock.

Top module: `fifo_thresh_loader`

## Requirements
- R1: The load mode is the value of `mode_strap_i` on the last clock edge with `rst_n` low: 1 selects serial loading, 0 selects parallel loading. Changes to the strap after reset have no effect until the next master reset.
- R2: On each clock edge with `rst_n` low, both offsets are set to min(2^(3+c)−1, DEPTH−1), where c = {mode_strap_i, sel_strap_i[1], sel_strap_i[0]} (values 7 to 1023). In the same cycle `rdata_o` is set to zero and `rdata_vld_o` to 0.
- R3: In parallel mode, every clock edge with `prog_i` and `wr_en_i` both high writes `wdata_i` to one offset. The target starts at the empty offset and then alternates with the full offset. Master reset sets the target back to the empty offset.
- R4: A parallel write with `wdata_i` ≥ DEPTH stores DEPTH−1.
- R5: In serial mode, every clock edge with `ser_en_i` high stores `ser_bit_i` into one offset bit. Bits go least significant first: log2(DEPTH) bits for the empty offset, then the same number for the full offset, and then the count wraps. Master reset restarts the count at bit 0 of the empty offset.
- R6: In parallel mode, `ser_en_i` has no effect on the offsets. In serial mode, `prog_i` together with `wr_en_i` has no effect on the offsets.
- R7: In both modes, a clock edge with `prog_i` and `rd_en_i` both high puts one offset on `rdata_o`, zero-extended, and sets `rdata_vld_o` for that single cycle. The first readback after reset returns the empty offset, and readbacks alternate after that. When no readback takes place, `rdata_vld_o` is 0.
- R8: When no write of the active mode takes place, the offsets keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Synchronous active-low master reset |
| mode_strap_i | input | 1 | Load-mode strap, sampled during reset (1 = serial) |
| sel_strap_i | input | 2 | Default-select straps, sampled during reset |
| prog_i | input | 1 | Program strobe for parallel writes and for readback |
| wr_en_i | input | 1 | Write enable for the parallel offset path |
| wdata_i | input | DATA_W | Parallel offset value taken from the write data bus |
| ser_en_i | input | 1 | Serial shift enable |
| ser_bit_i | input | 1 | Serial offset bit |
| rd_en_i | input | 1 | Read enable for offset readback |
| rdata_o | output | DATA_W | Offset readback value, zero-extended |
| rdata_vld_o | output | 1 | High for one cycle when `rdata_o` holds new readback data |
| empty_off_o | output | log2(DEPTH) | Current empty offset |
| full_off_o | output | log2(DEPTH) | Current full offset |

## Verification
The assertions assume three things. DEPTH is a power of two. The mode strap does not matter once reset has been released. Each write and readback check follows a clean edge with reset high. The stimulus meets these assumptions: it changes inputs only on falling clock edges, and it flips the straps only after reset has been released, so that R1 is exercised without disturbing the captured mode. Write values of 1024 and above cover the clamp, and a serial load is cut off by a reset partway through so that the bit count restart is checked.

// File: rtl/fifo_thresh_pkg.sv
// Shared types and the default-offset computation for the threshold loader.
// Assumes DEPTH is a power of two no larger than 2^31.
package fifo_thresh_pkg;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    // Default value for strap code c: 2^(3+c)-1, limited to depth-1.
    function automatic logic [31:0] default_offset(input logic [2:0] code,
                                                   input int unsigned depth);
        logic [31:0] val;
        val = (32'd1 << (32'd3 + {29'd0, code})) - 32'd1;
        if (val > depth - 1) begin
            val = depth - 1;
        end
        return val;
    endfunction

endpackage

// File: rtl/thl_strap_capture.sv
// Samples the load-mode strap while master reset is held and works out the
// default offset from the live straps.
// Assumes the straps are stable during the last reset cycle.
module thl_strap_capture
    import fifo_thresh_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int OW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_strap_i,
    input  logic [1:0]    sel_strap_i,
    output load_mode_e    load_mode_o,
    output logic [OW-1:0] dflt_o
);

    logic [31:0] dflt_full;

    // Work out the default pair value from the current strap code.
    always_comb begin
        dflt_full = default_offset({mode_strap_i, sel_strap_i}, DEPTH);
        dflt_o    = dflt_full[OW-1:0];
    end

    // Capture the load mode on every reset edge and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_mode_o <= load_mode_e'(mode_strap_i);
        end
    end

endmodule

// File: rtl/thl_par_writer.sv
// Parallel write path: decides which offset a write goes to and limits the
// value to DEPTH-1.
// Assumes DATA_W >= log2(DEPTH) and DEPTH fits in DATA_W bits.
module thl_par_writer
    import fifo_thresh_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 36,
    localparam int OW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  load_mode_e        load_mode_i,
    input  logic              prog_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              we_empty_o,
    output logic              we_full_o,
    output logic [OW-1:0]     val_o,
    output logic              ptr_o
);

    localparam logic [DATA_W-1:0] DEPTH_W = DATA_W'(DEPTH);
    localparam logic [OW-1:0]     MAX_OFF = OW'(DEPTH - 1);

    logic fire;

    // Decode the write strobe and choose the target register.
    always_comb begin
        fire       = (load_mode_i == LOAD_PAR) && prog_i && wr_en_i;
        we_empty_o = fire && !ptr_o;
        we_full_o  = fire && ptr_o;
    end

    // Limit out-of-range values to the largest legal offset.
    always_comb begin
        if (wdata_i >= DEPTH_W) begin
            val_o = MAX_OFF;
        end else begin
            val_o = wdata_i[OW-1:0];
        end
    end

    // Flip the target pointer after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= 1'b0;
        end else if (fire) begin
            ptr_o <= !ptr_o;
        end
    end

endmodule

// File: rtl/thl_ser_shifter.sv
// Serial write path: counts incoming bits and reports which offset and bit
// position the current bit goes to, least significant first, empty then full.
// Assumes DEPTH >= 4.
module thl_ser_shifter
    import fifo_thresh_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int OW   = $clog2(DEPTH),
    localparam int CW   = $clog2(2 * OW),
    localparam int PW   = $clog2(OW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  load_mode_e    load_mode_i,
    input  logic          ser_en_i,
    output logic          we_o,
    output logic          hit_full_o,
    output logic [PW-1:0] pos_o
);

    localparam logic [CW-1:0] LAST = CW'(2 * OW - 1);
    localparam logic [CW-1:0] HALF = CW'(OW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] rel;

    // Map the running count to a register and a bit position.
    always_comb begin
        we_o       = (load_mode_i == LOAD_SER) && ser_en_i;
        hit_full_o = (cnt >= HALF);
        rel        = hit_full_o ? (cnt - HALF) : cnt;
        pos_o      = rel[PW-1:0];
    end

    // Step the bit count on each shift and wrap after both registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (we_o) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/thl_readback.sv
// Readback path: presents the empty and full offsets in turn on the data
// bus, one per strobe, with a valid pulse.
// Assumes DATA_W >= log2(DEPTH).
module thl_readback #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 36,
    localparam int OW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic              rd_en_i,
    input  logic [OW-1:0]     empty_off_i,
    input  logic [OW-1:0]     full_off_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              vld_o,
    output logic              ptr_o
);

    logic          fire;
    logic [OW-1:0] sel_val;

    // Choose the register the next readback returns.
    always_comb begin
        fire    = prog_i && rd_en_i;
        sel_val = ptr_o ? full_off_i : empty_off_i;
    end

    // Register the readback word and its valid pulse, then flip the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            vld_o   <= 1'b0;
            ptr_o   <= 1'b0;
        end else begin
            vld_o <= fire;
            if (fire) begin
                rdata_o <= DATA_W'(sel_val);
                ptr_o   <= !ptr_o;
            end
        end
    end

endmodule

// File: rtl/fifo_thresh_loader.sv
// Top level of the threshold loader: holds the empty and full offset
// registers. Loads them with the strap default during reset, and after that
// from the parallel or serial path picked at reset. Readback is parallel only.
// Assumes DEPTH is a power of two >= 4 and DATA_W > log2(DEPTH).
module fifo_thresh_loader
    import fifo_thresh_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 36,
    localparam int OW    = $clog2(DEPTH),
    localparam int PW    = $clog2(OW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap_i,
    input  logic [1:0]        sel_strap_i,
    input  logic              prog_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ser_en_i,
    input  logic              ser_bit_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_vld_o,
    output logic [OW-1:0]     empty_off_o,
    output logic [OW-1:0]     full_off_o
);

    load_mode_e    load_mode;
    logic [OW-1:0] dflt;
    logic          par_we_empty;
    logic          par_we_full;
    logic [OW-1:0] par_val;
    logic          par_ptr;
    logic          ser_we;
    logic          ser_full;
    logic [PW-1:0] ser_pos;
    logic          rd_ptr;

    thl_strap_capture #(.DEPTH(DEPTH)) i_strap (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_strap_i (mode_strap_i),
        .sel_strap_i  (sel_strap_i),
        .load_mode_o  (load_mode),
        .dflt_o       (dflt)
    );

    thl_par_writer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_par (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_mode_i (load_mode),
        .prog_i      (prog_i),
        .wr_en_i     (wr_en_i),
        .wdata_i     (wdata_i),
        .we_empty_o  (par_we_empty),
        .we_full_o   (par_we_full),
        .val_o       (par_val),
        .ptr_o       (par_ptr)
    );

    thl_ser_shifter #(.DEPTH(DEPTH)) i_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_mode_i (load_mode),
        .ser_en_i    (ser_en_i),
        .we_o        (ser_we),
        .hit_full_o  (ser_full),
        .pos_o       (ser_pos)
    );

    thl_readback #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rb (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_i      (prog_i),
        .rd_en_i     (rd_en_i),
        .empty_off_i (empty_off_o),
        .full_off_i  (full_off_o),
        .rdata_o     (rdata_o),
        .vld_o       (rdata_vld_o),
        .ptr_o       (rd_ptr)
    );

    // Offset registers: default on reset, then whole-word or bit-wise updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_off_o <= dflt;
            full_off_o  <= dflt;
        end else begin
            if (par_we_empty) begin
                empty_off_o <= par_val;
            end
            if (par_we_full) begin
                full_off_o <= par_val;
            end
            for (int i = 0; i < OW; i++) begin
                if (ser_we && (ser_pos == PW'(i))) begin
                    if (ser_full) begin
                        full_off_o[i] <= ser_bit_i;
                    end else begin
                        empty_off_o[i] <= ser_bit_i;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fifo_thresh_loader_chk.sv
// Assertion checker for the threshold loader, bound into every instance.
// Assumes the parameters match the bound instance.
module fifo_thresh_loader_chk #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 36,
    localparam int OW    = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_mode,
    input logic              par_ptr,
    input logic              rd_ptr,
    input logic              prog_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              ser_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rdata_vld_o,
    input logic [OW-1:0]     empty_off_o,
    input logic [OW-1:0]     full_off_o
);

    localparam logic [DATA_W-1:0] DEPTH_W = DATA_W'(DEPTH);
    localparam logic [OW-1:0]     MAX_OFF = OW'(DEPTH - 1);

    // R1: the captured mode does not move while reset is released
    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(load_mode));

    // R4: an out-of-range parallel write to the empty offset stores the maximum
    a_r4_clamp_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mode && prog_i && wr_en_i && !par_ptr && (wdata_i >= DEPTH_W))
        |=> (empty_off_o == MAX_OFF));

    // R3: a parallel write aimed at the full offset leaves the empty offset alone
    a_r3_full_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mode && prog_i && wr_en_i && par_ptr) |=> $stable(empty_off_o));

    // R6: in parallel mode, no write strobe means no change
    a_r6_par_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mode && !(prog_i && wr_en_i))
        |=> ($stable(empty_off_o) && $stable(full_off_o)));

    // R6: in serial mode, no shift enable means no change
    a_r6_ser_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode && !ser_en_i)
        |=> ($stable(empty_off_o) && $stable(full_off_o)));

    // R7: valid rises exactly one cycle after a readback strobe
    a_r7_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_i && rd_en_i) |=> rdata_vld_o);

    // R7: no readback strobe means no valid pulse
    a_r7_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_i && rd_en_i) |=> !rdata_vld_o);

    // R7: the first readback of a pair returns the empty offset
    a_r7_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_i && rd_en_i && !rd_ptr)
        |=> (rdata_o == DATA_W'($past(empty_off_o))));

endmodule

bind fifo_thresh_loader fifo_thresh_loader_chk #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_mode   (load_mode),
    .par_ptr     (par_ptr),
    .rd_ptr      (rd_ptr),
    .prog_i      (prog_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .ser_en_i    (ser_en_i),
    .rd_en_i     (rd_en_i),
    .rdata_o     (rdata_o),
    .rdata_vld_o (rdata_vld_o),
    .empty_off_o (empty_off_o),
    .full_off_o  (full_off_o)
);

// File: tb/test_fifo_thresh_loader.sv
`timescale 1ns/1ps
// Scoreboard bench for the threshold loader. Drivers update a reference
// model and queue the expected readback words; a monitor pops and compares them.
module test_fifo_thresh_loader;

    localparam int DEPTH  = 1024;
    localparam int DATA_W = 36;
    localparam int OW     = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_strap = 1'b0;
    logic [1:0]        sel_strap = 2'b00;
    logic              prog = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic              ser_en = 1'b0;
    logic              ser_bit = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_vld;
    logic [OW-1:0]     empty_off;
    logic [OW-1:0]     full_off;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model
    logic          m_mode;
    logic [OW-1:0] m_empty, m_full;
    logic          m_wptr, m_rptr;
    int            m_cnt;
    logic [DATA_W-1:0] exp_q[$];

    fifo_thresh_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo_thresh_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_strap_i (mode_strap),
        .sel_strap_i  (sel_strap),
        .prog_i       (prog),
        .wr_en_i      (wr_en),
        .wdata_i      (wdata),
        .ser_en_i     (ser_en),
        .ser_bit_i    (ser_bit),
        .rd_en_i      (rd_en),
        .rdata_o      (rdata),
        .rdata_vld_o  (rdata_vld),
        .empty_off_o  (empty_off),
        .full_off_o   (full_off)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] dflt(input logic [2:0] c);
        int v;
        v = (1 << (3 + c)) - 1;
        if (v > DEPTH - 1) v = DEPTH - 1;
        return OW'(v);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compare every valid readback word with the queue head (R7).
    always @(negedge clk) begin
        if (rst_n && rdata_vld) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7: actual %0d expected no readback", rdata);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL R7: actual %0d expected %0d", rdata, e);
                end
            end
        end
    end

    task automatic do_reset(input logic m, input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0; mode_strap = m; sel_strap = s;
        prog = 0; wr_en = 0; ser_en = 0; rd_en = 0;
        repeat (2) @(negedge clk);
        check("R2 vld in reset", 64'(rdata_vld), 64'd0);
        check("R2 rdata in reset", 64'(rdata), 64'd0);
        rst_n = 1'b1;
        m_mode = m; m_empty = dflt({m, s}); m_full = m_empty;
        m_wptr = 0; m_rptr = 0; m_cnt = 0;
        mode_strap = ~m; sel_strap = ~s;   // R1: later strap changes must not matter
        @(negedge clk);
        check("R2 empty default", 64'(empty_off), 64'(m_empty));
        check("R2 full default", 64'(full_off), 64'(m_full));
    endtask

    task automatic par_write(input logic [DATA_W-1:0] v, input string tag);
        logic [OW-1:0] cv;
        prog = 1; wr_en = 1; wdata = v;
        cv = (v >= DATA_W'(DEPTH)) ? OW'(DEPTH - 1) : v[OW-1:0];
        if (!m_mode) begin
            if (m_wptr) m_full = cv; else m_empty = cv;
            m_wptr = ~m_wptr;
        end
        @(negedge clk);
        prog = 0; wr_en = 0;
        check({tag, " empty"}, 64'(empty_off), 64'(m_empty));
        check({tag, " full"}, 64'(full_off), 64'(m_full));
    endtask

    task automatic ser_shift(input logic [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            ser_en = 1; ser_bit = bits[i];
            if (m_mode) begin
                if (m_cnt < OW) m_empty[m_cnt] = bits[i];
                else m_full[m_cnt - OW] = bits[i];
                m_cnt = (m_cnt == 2 * OW - 1) ? 0 : m_cnt + 1;
            end
            @(negedge clk);
        end
        ser_en = 0;
    endtask

    task automatic read_back(input int n);
        for (int i = 0; i < n; i++) begin
            prog = 1; rd_en = 1;
            exp_q.push_back(DATA_W'(m_rptr ? m_full : m_empty));
            m_rptr = ~m_rptr;
            @(negedge clk);
        end
        prog = 0; rd_en = 0;
        @(negedge clk);
        check("R7 queue drained", 64'(exp_q.size()), 64'd0);
        check("R7 vld idle", 64'(rdata_vld), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R2: defaults for several strap codes
        do_reset(1'b0, 2'b00);   // code 0 -> 7
        do_reset(1'b0, 2'b11);   // code 3 -> 63
        do_reset(1'b1, 2'b01);   // code 5 -> 255
        do_reset(1'b1, 2'b11);   // code 7 -> 1023

        // Parallel mode: R3 order, R4 clamp, R6 serial ignored, R8 hold
        do_reset(1'b0, 2'b01);   // code 1 -> 15
        par_write(36'd100, "R3 first to empty");
        par_write(36'd200, "R3 second to full");
        par_write(36'd5000, "R4 clamp empty");
        par_write(36'd1024, "R4 clamp full");
        par_write(36'd300, "R3 wrap to empty");
        ser_shift(32'h000F_FFFF, 20);
        check("R6 ser ignored empty", 64'(empty_off), 64'(m_empty));
        check("R6 ser ignored full", 64'(full_off), 64'(m_full));
        repeat (3) @(negedge clk);
        check("R8 hold empty", 64'(empty_off), 64'd300);
        check("R8 hold full", 64'(full_off), 64'd1023);
        read_back(3);            // R7: empty, full, empty

        // Serial mode: R5 order, R6 parallel ignored, R1 mode held
        do_reset(1'b1, 2'b00);   // code 4 -> 127
        par_write(36'd9, "R6 par ignored");
        ser_shift(32'h0000_02A5, 10);
        check("R5 empty after 10 bits", 64'(empty_off), 64'h2A5);
        check("R5 full untouched", 64'(full_off), 64'd127);
        ser_shift(32'h0000_013C, 10);
        check("R5 full after 20 bits", 64'(full_off), 64'h13C);
        check("R1 serial kept", 64'(empty_off), 64'h2A5);
        read_back(4);            // R7 in serial mode

        // R5: wrap back to the empty offset after 2*OW bits
        ser_shift(32'h0000_0055, 10);
        check("R5 wrap to empty", 64'(empty_off), 64'h055);

        // R5: reset partway through restarts the count
        do_reset(1'b1, 2'b10);   // code 6 -> 511
        ser_shift(32'h0000_0007, 3);
        do_reset(1'b1, 2'b10);
        ser_shift(32'h0000_0001, 10);
        check("R5 count restart empty", 64'(empty_off), 64'd1);
        check("R5 count restart full", 64'(full_off), 64'd511);
        read_back(2);

        finish_run();
    end

endmodule